// File: doc/BRIEF.md
# Complex Butterfly Arithmetic Datapath

A pipelined fixed-point unit for radix-2 FFT stages and complex vector work. Each transaction carries two complex operands A and B, a complex twiddle W and a two-bit operation code. The complex product P = W·B is formed by four real multipliers working in parallel: br·wr, bi·wi, br·wi and bi·wr. A subtractor then combines these into the real part of P and an adder into the imaginary part. Two add-subtract lanes, one for the real parts and one for the imaginary parts, each produce a sum and a difference in the same cycle. A butterfly therefore costs ten arithmetic operations, and a new one can start every clock.

Values are signed Q15 in 16 bits. The product is kept at full precision until the last stage. There it is rounded to Q15 (round half up) and saturated, or added to and subtracted from A with saturation. A multiply-accumulate adds the unrounded Q30 product into a 40-bit complex accumulator. Transactions enter through a valid/ready handshake and leave through another one. When the consumer holds off, the whole pipeline freezes. Results come back in order, together with the operation code that produced them.

Top module: `cbfly_top`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, out_valid is 0, y0/y1 are 0, acc_re/acc_im are 0 and in_ready is 1.
- R2: Operation code 00 (multiply) returns y0 = sat(round(W·B)) and y1 = 0. The real part of W·B is br·wr − bi·wi and the imaginary part is br·wi + bi·wr. Operation codes 01 and 11 return y0 = y1 = 0.
- R3: Operation code 10 (butterfly) returns y0 = sat(A + round(W·B)) and y1 = sat(A − round(W·B)), each taken per real and imaginary part.
- R4: Every y output saturates to the range −32768 to 32767 instead of wrapping.
- R5: Operation code 01 (multiply-accumulate) adds the unrounded 32-bit-scale product, sign-extended, to the accumulator. The sum wraps modulo 2^40. Every result reports on acc_re/acc_im the accumulator value after its own operation has been applied.
- R6: Operation code 11 clears both accumulator parts, and its result reports acc_re = acc_im = 0.
- R7: With out_ready held high, the result of a transaction accepted at rising edge k is presented after rising edge k+2, so it is visible during the cycle after the third edge counted from acceptance. out_op echoes the operation code, and results leave in acceptance order, one for each accepted transaction.
- R8: With out_ready high, in_ready stays high, and one transaction is accepted on every cycle.
- R9: While out_valid is 1 and out_ready is 0, all outputs hold their values on the next cycle, and the accumulator does not advance.
- R10: Rounding from Q30 to Q15 adds 2^14 and then shifts right arithmetically by 15. Thus 0.5 LSB rounds up and −1.5 LSB rounds to −1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transaction present on the inputs |
| in_ready | output | 1 | Block accepts a transaction this cycle |
| in_op | input | 2 | 00 multiply, 01 multiply-accumulate, 10 butterfly, 11 clear accumulator |
| a_re | input | 16 | Operand A real, Q15 |
| a_im | input | 16 | Operand A imaginary, Q15 |
| b_re | input | 16 | Operand B real, Q15 |
| b_im | input | 16 | Operand B imaginary, Q15 |
| w_re | input | 16 | Twiddle real, Q15 |
| w_im | input | 16 | Twiddle imaginary, Q15 |
| out_valid | output | 1 | Result present on the outputs |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_op | output | 2 | Operation code of the result |
| y0_re | output | 16 | Upper or single result, real |
| y0_im | output | 16 | Upper or single result, imaginary |
| y1_re | output | 16 | Lower butterfly result, real |
| y1_im | output | 16 | Lower butterfly result, imaginary |
| acc_re | output | 40 | Accumulator real part after this operation |
| acc_im | output | 40 | Accumulator imaginary part after this operation |

## Verification
A transaction counts as accepted when in_valid and in_ready are both high at a rising edge. With no backpressure, its result is due in the cycle after the third edge counted from acceptance. The bench samples in_ready and drives stimulus just after falling edges, and records the cycle of each acceptance. Outputs are checked one falling edge plus a small delay later, and in the no-stall phase the bench requires that every result be consumed exactly three cycles after its acceptance. In the stalled phase, order and values are checked through an in-order expectation queue, and any held result is compared with its values from the previous cycle.

// File: rtl/cbfly_pkg.sv
package cbfly_pkg;

  typedef enum logic [1:0] {
    OP_CMUL = 2'b00,
    OP_MAC  = 2'b01,
    OP_BFLY = 2'b10,
    OP_CLR  = 2'b11
  } op_e;

endpackage

// File: rtl/cbfly_mul4.sv
// Stage 1: four real products of B and W in parallel; A travels alongside.
module cbfly_mul4 #(
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  in_v,
  input  logic [1:0]            in_op,
  input  logic signed [DW-1:0]  a_re,
  input  logic signed [DW-1:0]  a_im,
  input  logic signed [DW-1:0]  b_re,
  input  logic signed [DW-1:0]  b_im,
  input  logic signed [DW-1:0]  w_re,
  input  logic signed [DW-1:0]  w_im,
  output logic                  v_q,
  output logic [1:0]            op_q,
  output logic signed [DW-1:0]  a_re_q,
  output logic signed [DW-1:0]  a_im_q,
  output logic signed [2*DW-1:0] p_rr,
  output logic signed [2*DW-1:0] p_ii,
  output logic signed [2*DW-1:0] p_ri,
  output logic signed [2*DW-1:0] p_ir
);
  localparam int MW = 2 * DW;
  localparam int NMUL = 4;

  logic signed [DW-1:0] mx [NMUL];
  logic signed [DW-1:0] my [NMUL];
  logic signed [MW-1:0] pq [NMUL];

  assign mx[0] = b_re;  assign my[0] = w_re;
  assign mx[1] = b_im;  assign my[1] = w_im;
  assign mx[2] = b_re;  assign my[2] = w_im;
  assign mx[3] = b_im;  assign my[3] = w_re;

  for (genvar g = 0; g < NMUL; g++) begin : g_mul
    always_ff @(posedge clk) begin
      if (rst)     pq[g] <= '0;
      else if (en) pq[g] <= MW'(mx[g]) * MW'(my[g]);
    end
  end

  assign p_rr = pq[0];
  assign p_ii = pq[1];
  assign p_ri = pq[2];
  assign p_ir = pq[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      op_q   <= '0;
      a_re_q <= '0;
      a_im_q <= '0;
    end else if (en) begin
      v_q    <= in_v;
      op_q   <= in_op;
      a_re_q <= a_re;
      a_im_q <= a_im;
    end
  end
endmodule

// File: rtl/cbfly_combine.sv
// Stage 2: one subtractor and one adder form W*B; the accumulator lives here.
module cbfly_combine
  import cbfly_pkg::*;
#(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   v_in,
  input  logic [1:0]             op_in,
  input  logic signed [DW-1:0]   a_re_in,
  input  logic signed [DW-1:0]   a_im_in,
  input  logic signed [2*DW-1:0] p_rr,
  input  logic signed [2*DW-1:0] p_ii,
  input  logic signed [2*DW-1:0] p_ri,
  input  logic signed [2*DW-1:0] p_ir,
  output logic                   v_q,
  output logic [1:0]             op_q,
  output logic signed [DW-1:0]   a_re_q,
  output logic signed [DW-1:0]   a_im_q,
  output logic signed [2*DW:0]   prod_re,
  output logic signed [2*DW:0]   prod_im,
  output logic signed [ACCW-1:0] acc_re,
  output logic signed [ACCW-1:0] acc_im
);
  localparam int PW = 2 * DW + 1;

  logic signed [PW-1:0]   s_re, s_im;
  logic signed [ACCW-1:0] x_re, x_im;
  logic                   do_mac, do_clr;

  assign s_re = PW'(p_rr) - PW'(p_ii);
  assign s_im = PW'(p_ri) + PW'(p_ir);
  assign x_re = ACCW'(s_re);
  assign x_im = ACCW'(s_im);

  assign do_mac = v_in && (op_e'(op_in) == OP_MAC);
  assign do_clr = v_in && (op_e'(op_in) == OP_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= 1'b0;
      op_q    <= '0;
      a_re_q  <= '0;
      a_im_q  <= '0;
      prod_re <= '0;
      prod_im <= '0;
    end else if (en) begin
      v_q     <= v_in;
      op_q    <= op_in;
      a_re_q  <= a_re_in;
      a_im_q  <= a_im_in;
      prod_re <= s_re;
      prod_im <= s_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (en) begin
      if (do_clr) begin
        acc_re <= '0;
        acc_im <= '0;
      end else if (do_mac) begin
        acc_re <= acc_re + x_re;
        acc_im <= acc_im + x_im;
      end
    end
  end
endmodule

// File: rtl/cbfly_addsub.sv
// One add-subtract lane: rounds the product to Q15 and forms A+P and A-P.
module cbfly_addsub #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [2*DW:0] prod,
  output logic signed [DW-1:0] r_sat,
  output logic signed [DW-1:0] sum_sat,
  output logic signed [DW-1:0] dif_sat
);
  localparam int PW = 2 * DW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(64'd1 << (DW - 2));
  localparam logic signed [PW-1:0] HI   = PW'((64'd1 << (DW - 1)) - 64'd1);
  localparam logic signed [PW-1:0] LO   = ~HI;

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] x);
    logic signed [PW-1:0] y;
    if (x > HI)      y = HI;
    else if (x < LO) y = LO;
    else             y = x;
    return DW'(y);
  endfunction

  logic signed [PW-1:0] rnd, r, ae;

  assign rnd = prod + HALF;
  assign r   = rnd >>> (DW - 1);
  assign ae  = PW'(a);

  assign r_sat   = sat(r);
  assign sum_sat = sat(ae + r);
  assign dif_sat = sat(ae - r);
endmodule

// File: rtl/cbfly_top.sv
module cbfly_top
  import cbfly_pkg::*;
#(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [1:0]             in_op,
  input  logic signed [DW-1:0]   a_re,
  input  logic signed [DW-1:0]   a_im,
  input  logic signed [DW-1:0]   b_re,
  input  logic signed [DW-1:0]   b_im,
  input  logic signed [DW-1:0]   w_re,
  input  logic signed [DW-1:0]   w_im,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [1:0]             out_op,
  output logic signed [DW-1:0]   y0_re,
  output logic signed [DW-1:0]   y0_im,
  output logic signed [DW-1:0]   y1_re,
  output logic signed [DW-1:0]   y1_im,
  output logic signed [ACCW-1:0] acc_re,
  output logic signed [ACCW-1:0] acc_im
);
  localparam int MW    = 2 * DW;
  localparam int PW    = 2 * DW + 1;
  localparam int LANES = 2;

  // a single enable freezes all three stages while a result waits
  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  logic                 v1, v2;
  logic [1:0]           op1, op2;
  logic signed [DW-1:0] a1_re, a1_im, a2_re, a2_im;
  logic signed [MW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [PW-1:0] pr_re, pr_im;
  logic signed [ACCW-1:0] acc_q_re, acc_q_im;

  cbfly_mul4 #(.DW(DW)) u_mul (
    .clk(clk), .rst(rst), .en(en), .in_v(in_valid), .in_op(in_op),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .w_re(w_re), .w_im(w_im),
    .v_q(v1), .op_q(op1), .a_re_q(a1_re), .a_im_q(a1_im),
    .p_rr(p_rr), .p_ii(p_ii), .p_ri(p_ri), .p_ir(p_ir)
  );

  cbfly_combine #(.DW(DW), .ACCW(ACCW)) u_cmb (
    .clk(clk), .rst(rst), .en(en), .v_in(v1), .op_in(op1),
    .a_re_in(a1_re), .a_im_in(a1_im),
    .p_rr(p_rr), .p_ii(p_ii), .p_ri(p_ri), .p_ir(p_ir),
    .v_q(v2), .op_q(op2), .a_re_q(a2_re), .a_im_q(a2_im),
    .prod_re(pr_re), .prod_im(pr_im),
    .acc_re(acc_q_re), .acc_im(acc_q_im)
  );

  // lane 0 = real parts, lane 1 = imaginary parts
  logic signed [DW-1:0] lane_a [LANES];
  logic signed [PW-1:0] lane_p [LANES];
  logic signed [DW-1:0] lane_r [LANES];
  logic signed [DW-1:0] lane_s [LANES];
  logic signed [DW-1:0] lane_d [LANES];

  assign lane_a[0] = a2_re;  assign lane_p[0] = pr_re;
  assign lane_a[1] = a2_im;  assign lane_p[1] = pr_im;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cbfly_addsub #(.DW(DW)) u_as (
      .a(lane_a[g]), .prod(lane_p[g]),
      .r_sat(lane_r[g]), .sum_sat(lane_s[g]), .dif_sat(lane_d[g])
    );
  end

  // stage 3: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_op    <= '0;
      y0_re     <= '0;
      y0_im     <= '0;
      y1_re     <= '0;
      y1_im     <= '0;
      acc_re    <= '0;
      acc_im    <= '0;
    end else if (en) begin
      out_valid <= v2;
      out_op    <= op2;
      acc_re    <= acc_q_re;
      acc_im    <= acc_q_im;
      case (op_e'(op2))
        OP_CMUL: begin
          y0_re <= lane_r[0];
          y0_im <= lane_r[1];
          y1_re <= '0;
          y1_im <= '0;
        end
        OP_BFLY: begin
          y0_re <= lane_s[0];
          y0_im <= lane_s[1];
          y1_re <= lane_d[0];
          y1_im <= lane_d[1];
        end
        default: begin
          y0_re <= '0;
          y0_im <= '0;
          y1_re <= '0;
          y1_im <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cbfly_chk.sv
module cbfly_chk #(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [1:0]             out_op,
  input logic signed [DW-1:0]   y0_re,
  input logic signed [DW-1:0]   y0_im,
  input logic signed [DW-1:0]   y1_re,
  input logic signed [DW-1:0]   y1_im,
  input logic signed [ACCW-1:0] acc_re,
  input logic signed [ACCW-1:0] acc_im
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !out_valid && acc_re == '0 && acc_im == '0);

  // R2
  single_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_op != 2'b10 |-> y1_re == '0 && y1_im == '0);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_op == 2'b11 |-> acc_re == '0 && acc_im == '0);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_op) &&
      $stable(y0_re) && $stable(y0_im) && $stable(y1_re) && $stable(y1_im) &&
      $stable(acc_re) && $stable(acc_im));
endmodule

bind cbfly_top cbfly_chk #(.DW(DW), .ACCW(ACCW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_op(out_op), .y0_re(y0_re), .y0_im(y0_im),
  .y1_re(y1_re), .y1_im(y1_im), .acc_re(acc_re), .acc_im(acc_im)
);

// File: tb/cbfly_top_tb.sv
module cbfly_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [1:0] in_op = 2'b00;
  logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, w_re = '0, w_im = '0;
  logic in_ready, out_valid;
  logic [1:0] out_op;
  logic signed [15:0] y0_re, y0_im, y1_re, y1_im;
  logic signed [39:0] acc_re, acc_im;

  always #4 clk = ~clk;

  cbfly_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re), .y1_im(y1_im),
    .acc_re(acc_re), .acc_im(acc_im)
  );

  typedef struct {
    logic [1:0] op;
    longint y0r, y0i, y1r, y1i, accr, acci, cyc;
    bit timed;
    string tag;
  } exp_t;

  exp_t   q[$];
  int     errors = 0, checks = 0, retries = 0;
  longint cyc = 0;
  bit     stall_en = 1'b0;
  longint macc_re = 0, macc_im = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat16(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic longint wrap40(longint x);
    logic signed [39:0] t;
    t = x[39:0];
    return longint'(t);
  endfunction

  function automatic int cval(int i);
    case (i % 8)
      0: return -32768;
      1: return -32767;
      2: return -16384;
      3: return -1;
      4: return 0;
      5: return 1;
      6: return 16384;
      default: return 32767;
    endcase
  endfunction

  task automatic send(logic [1:0] op, int ar, int ai, int br, int bi,
                      int wr, int wi, string tag);
    exp_t e;
    longint pre, pim, rre, rim;
    @(negedge clk);
    in_valid = 1'b1; in_op = op;
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br);
    b_im = 16'(bi); w_re = 16'(wr); w_im = 16'(wi);
    #1;
    while (!in_ready) begin
      if (!stall_en) retries++;
      @(negedge clk); #1;
    end
    pre = longint'(br) * wr - longint'(bi) * wi;
    pim = longint'(br) * wi + longint'(bi) * wr;
    rre = (pre + 16384) >>> 15;
    rim = (pim + 16384) >>> 15;
    e.op = op; e.y0r = 0; e.y0i = 0; e.y1r = 0; e.y1i = 0;
    e.tag = tag;
    case (op)
      2'b00: begin
        e.y0r = sat16(rre); e.y0i = sat16(rim);
        if (tag == "") e.tag = "R2";
      end
      2'b01: begin
        macc_re = wrap40(macc_re + pre); macc_im = wrap40(macc_im + pim);
        if (tag == "") e.tag = "R5";
      end
      2'b10: begin
        e.y0r = sat16(ar + rre); e.y0i = sat16(ai + rim);
        e.y1r = sat16(ar - rre); e.y1i = sat16(ai - rim);
        if (tag == "") e.tag = "R3";
      end
      default: begin
        macc_re = 0; macc_im = 0;
        if (tag == "") e.tag = "R6";
      end
    endcase
    e.accr = macc_re; e.acci = macc_im;
    e.cyc = cyc; e.timed = !stall_en;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int n = 0; n < 400 && q.size() != 0; n++) @(negedge clk);
  endtask

  // backpressure driver
  initial begin
    forever begin
      @(negedge clk);
      out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // output monitor
  bit prev_hold = 1'b0;
  longint h_op, h0r, h0i, h1r, h1i, har, hai;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (prev_hold) begin
        chk("R9", out_valid, 1);
        chk("R9", out_op, h_op);
        chk("R9", y0_re, h0r); chk("R9", y0_im, h0i);
        chk("R9", y1_re, h1r); chk("R9", y1_im, h1i);
        chk("R9", acc_re, har); chk("R9", acc_im, hai);
      end
      prev_hold = out_valid && !out_ready;
      h_op = out_op; h0r = y0_re; h0i = y0_im; h1r = y1_re; h1i = y1_im;
      har = acc_re; hai = acc_im;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk("R7", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.timed) chk("R7", cyc, e.cyc + 3);
          chk("R7", out_op, e.op);
          chk(e.tag, y0_re, e.y0r); chk(e.tag, y0_im, e.y0i);
          chk(e.tag, y1_re, e.y1r); chk(e.tag, y1_im, e.y1i);
          chk(e.tag, acc_re, e.accr); chk(e.tag, acc_im, e.acci);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1: reset state
    chk("R1", out_valid, 0); chk("R1", in_ready, 1);
    chk("R1", acc_re, 0); chk("R1", acc_im, 0);
    chk("R1", y0_re, 0); chk("R1", y1_im, 0);

    // R10: rounding, half up
    send(2'b00, 0, 0, 1, 0, 16384, 0, "R10");
    send(2'b00, 0, 0, -1, 0, 16384, 0, "R10");
    send(2'b00, 0, 0, -3, 0, 16384, 0, "R10");
    send(2'b00, 0, 0, 3, 0, 16384, 0, "R10");
    // R4: saturation in both directions
    send(2'b10, 32767, -32768, 32767, 0, 32767, 0, "R4");
    send(2'b00, 0, 0, -32768, -32768, -32768, 32767, "R4");
    send(2'b10, -32768, 32767, -32768, -32768, -32768, 32767, "R4");
    // R5 / R6: accumulate a large product, then clear
    send(2'b11, 0, 0, 0, 0, 0, 0, "R6");
    for (int n = 0; n < 20; n++)
      send(2'b01, 0, 0, -32768, -32768, -32768, 32767, "R5");
    send(2'b00, 5, 5, 100, 200, 300, 400, "R5");
    send(2'b11, 0, 0, 0, 0, 0, 0, "R6");
    send(2'b01, 0, 0, 1234, -567, -8900, 4321, "R5");
    // corner sweep, all operations back to back
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 8; k++)
          send(2'((i + j + k) % 4), cval(i), cval(i + j), cval(j),
               cval(j + k), cval(k), cval(k + i + 3), "");
    idle();
    drain();
    // R8: no backpressure means no waiting
    chk("R8", retries, 0);

    // random phase under backpressure
    stall_en = 1'b1;
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom % 8;
      send(r < 3 ? 2'b10 : (r < 5 ? 2'b01 : (r < 7 ? 2'b00 : 2'b11)),
           int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768,
           int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768,
           int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768,
           r < 5 && r >= 3 ? "R5" : (r < 3 ? "R9" : ""));
    end
    idle();
    drain();
    stall_en = 1'b0;
    repeat (4) @(negedge clk);
    // R7: one result per accepted transaction
    chk("R7", q.size(), 0);
    finish_run();
  end
endmodule